// File: doc/BRIEF.md
# Configuration Chain Memory

This block stores the configuration bits that program a multiplexer or a similar programmable circuit. The bits sit in a serial string of flip-flop cells. A loader feeds one bit per clock into the head of the string while the shift enable is high. Whatever leaves the last cell appears on the tail pin, so several such blocks can be strung together into one long chain.

Each cell has three outputs. The chain output feeds the next cell. A gated data output and its complement go to the configured circuit. The gated outputs keep their old value for as long as shifting goes on. They take the new cell contents on the first clock edge after shifting stops, so the configured circuit never sees a half-loaded pattern. A build option lets every cell also take a second scan input. That input is wired to the same predecessor as the normal serial input, and the cell shifts from it.

Top module: `cfgmem_chain`

## Requirements
- R1: A synchronous active-high reset clears every cell. The clock edge that samples reset drives `cfg_data` to all zeros, `cfg_data_n` to all ones and `chain_tail` to 0.
- R2: On each rising edge with `cfg_en` high, cell 0 takes `chain_head` and cell i takes the old contents of cell i-1.
- R3: `chain_tail` always shows the contents of cell N-1. A bit fed at the head on a shift edge reaches the tail N-1 shift edges later.
- R4: While `cfg_en` is high, `cfg_data` and `cfg_data_n` do not change.
- R5: On a rising edge with `cfg_en` low, bit i of `cfg_data` takes the contents of cell i. After N shifts, `cfg_data[N-1]` holds the first bit fed and `cfg_data[0]` holds the last bit fed.
- R6: `cfg_data_n` is always the bitwise complement of `cfg_data`.
- R7: While `cfg_en` is low, `chain_head` has no effect: the cells and `chain_tail` keep their contents.
- R8: Reset asserted in the middle of a shift sequence discards the partly loaded pattern and returns the block to the R1 state.
- R9: When the scan option is built in, each cell's scan input and primary serial input come from the same predecessor (the head for cell 0), and the cell shifts from the scan input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_en | input | 1 | Shift enable; high shifts the chain and freezes the data buses |
| chain_head | input | 1 | Serial data into cell 0 |
| chain_tail | output | 1 | Serial data out of cell N-1 |
| cfg_data | output | N_BITS | Gated true configuration bits, bit i from cell i |
| cfg_data_n | output | N_BITS | Gated inverted configuration bits, bit i from cell i |

## Verification
The hardest thing to see from the ports is that the buses stay frozen while the cells underneath change, and that the tail gives out the old contents in the right order during a reload. All the cells start at zero, so a first load proves little. The stimulus therefore loads and publishes a known, asymmetric word first. It then shifts in a second, different word. On every shift edge it checks the tail against the old word, bit by bit from the top, and checks that the buses still show the old word. Single-set-bit patterns at both ends of the word show that the bit order is not reversed.

// File: rtl/cfgmem_pkg.sv
package cfgmem_pkg;
    typedef struct packed {
        logic chain;   // serial storage bit
        logic data;    // gated true output
        logic data_n;  // gated inverted output
    } cell_state_t;

    localparam cell_state_t CELL_RESET = '{chain: 1'b0, data: 1'b0, data_n: 1'b1};
endpackage

// File: rtl/cfgmem_cell.sv
module cfgmem_cell
    import cfgmem_pkg::*;
#(
    parameter bit HAS_SCAN = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic shift_en,
    input  logic din,
    input  logic scan_din,
    output logic chain_q,
    output logic cfg_q,
    output logic cfg_qn
);
    cell_state_t s_d, s_q;
    logic        shift_src;

    generate
        if (HAS_SCAN) begin : g_scan
            assign shift_src = scan_din;
            // R9: scan and primary inputs share one predecessor
            assert_scan_src_R9: assert property (@(posedge clk) disable iff (rst)
                scan_din == din);
        end else begin : g_plain
            assign shift_src = din;
            logic unused_scan;
            assign unused_scan = scan_din;
        end
    endgenerate

    always_comb begin
        s_d = s_q;
        if (shift_en) begin
            s_d.chain = shift_src;
        end else begin
            s_d.data   = s_q.chain;
            s_d.data_n = ~s_q.chain;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= CELL_RESET;
        else     s_q <= s_d;
    end

    assign chain_q = s_q.chain;
    assign cfg_q   = s_q.data;
    assign cfg_qn  = s_q.data_n;

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> ($stable(cfg_q) && $stable(cfg_qn)));

    assert_load_R5: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> (cfg_q == $past(chain_q) && cfg_qn == !$past(chain_q)));
endmodule

// File: rtl/cfgmem_chain.sv
module cfgmem_chain #(
    parameter int unsigned N_BITS   = 8,
    parameter bit          HAS_SCAN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_en,
    input  logic              chain_head,
    output logic              chain_tail,
    output logic [N_BITS-1:0] cfg_data,
    output logic [N_BITS-1:0] cfg_data_n
);
    localparam int unsigned LINKS = N_BITS + 1;

    logic [LINKS-1:0] link;

    assign link[0] = chain_head;

    generate
        for (genvar i = 0; i < N_BITS; i++) begin : g_cell
            cfgmem_cell #(.HAS_SCAN(HAS_SCAN)) u_cell (
                .clk      (clk),
                .rst      (rst),
                .shift_en (cfg_en),
                .din      (link[i]),
                .scan_din (link[i]),
                .chain_q  (link[i+1]),
                .cfg_q    (cfg_data[i]),
                .cfg_qn   (cfg_data_n[i])
            );
        end
    endgenerate

    assign chain_tail = link[N_BITS];

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (cfg_data == '0 && cfg_data_n == '1 && chain_tail == 1'b0));

    assert_head_R2: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> link[1] == $past(chain_head));

    assert_inv_R6: assert property (@(posedge clk) disable iff (rst)
        cfg_data_n == ~cfg_data);

    assert_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> $stable(chain_tail));
endmodule

// File: tb/tb_cfgmem_chain.sv
module tb_cfgmem_chain;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cfg_en = 1'b0;
    logic         chain_head = 1'b0;
    logic         chain_tail;
    logic [N-1:0] cfg_data, cfg_data_n;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cfgmem_chain #(.N_BITS(N), .HAS_SCAN(1'b1)) dut (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .chain_head(chain_head),
        .chain_tail(chain_tail), .cfg_data(cfg_data), .cfg_data_n(cfg_data_n)
    );

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // feed w[N-1] first, w[0] last; one shift per edge; ends at negedge
    task automatic shift_word(input logic [N-1:0] w);
        for (int k = N - 1; k >= 0; k--) begin
            cfg_en = 1'b1; chain_head = w[k];
            @(negedge clk);
        end
        cfg_en = 1'b0;
    endtask

    task automatic publish();
        cfg_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 data", cfg_data, '0);
        check("R1 data_n", cfg_data_n, '1);
        check("R1 tail", {{(N-1){1'b0}}, chain_tail}, '0);
        rst = 1'b0;
    endtask

    task automatic t_load(input logic [N-1:0] w);
        shift_word(w);
        check("R3 tail after load", {{(N-1){1'b0}}, chain_tail}, {{(N-1){1'b0}}, w[N-1]});
        publish();
        check("R2 R5 data", cfg_data, w);
        check("R6 data_n", cfg_data_n, ~w);
    endtask

    task automatic t_reload(input logic [N-1:0] old_w, input logic [N-1:0] new_w);
        for (int j = 1; j <= N; j++) begin
            cfg_en = 1'b1; chain_head = new_w[N-j];
            @(negedge clk);
            check("R4 hold data", cfg_data, old_w);
            check("R4 hold data_n", cfg_data_n, ~old_w);
            if (j < N)
                check("R3 tail order", {{(N-1){1'b0}}, chain_tail}, {{(N-1){1'b0}}, old_w[N-1-j]});
            else
                check("R3 tail new", {{(N-1){1'b0}}, chain_tail}, {{(N-1){1'b0}}, new_w[N-1]});
        end
        publish();
        check("R5 reload data", cfg_data, new_w);
        check("R9 scan path data", cfg_data, new_w);
    endtask

    task automatic t_idle(input logic [N-1:0] w);
        for (int j = 0; j < 5; j++) begin
            cfg_en = 1'b0; chain_head = ~chain_head;
            @(negedge clk);
            check("R7 idle tail", {{(N-1){1'b0}}, chain_tail}, {{(N-1){1'b0}}, w[N-1]});
        end
        check("R7 idle data", cfg_data, w);
        // brought out: the cells still hold w
        cfg_en = 1'b1; chain_head = 1'b0;
        @(negedge clk);
        check("R7 cells kept", {{(N-1){1'b0}}, chain_tail}, {{(N-1){1'b0}}, w[N-2]});
        cfg_en = 1'b0;
    endtask

    task automatic t_mid_reset();
        cfg_en = 1'b1;
        for (int j = 0; j < 3; j++) begin
            chain_head = 1'b1;
            @(negedge clk);
        end
        rst = 1'b1;
        @(negedge clk);
        check("R8 data", cfg_data, '0);
        check("R8 data_n", cfg_data_n, '1);
        check("R8 tail", {{(N-1){1'b0}}, chain_tail}, '0);
        rst = 1'b0; cfg_en = 1'b0;
        publish();
        check("R8 cells clear", cfg_data, '0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_load(8'hA5);
        t_reload(8'hA5, 8'h3C);
        t_idle(8'h3C);
        t_load(8'h01);
        t_load(8'h80);
        t_load(8'hFF);
        t_load(8'h00);
        t_mid_reset();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule